// File: doc/BRIEF.md
# SPI Serial Flash Device Front-End

This block is the device side of a serial flash memory, built entirely in the system clock domain. It oversamples the chip select, serial clock and serial data input, and assembles a one-byte opcode followed by any address and data bytes. It answers identification requests and keeps a status byte holding a busy flag, a write-enable latch and a three-bit protection level. It programs and erases a small parameterized backing array, and it has a deep power-down state.

Program, erase and status writes are collected while the device is selected. They are applied only when chip select rises on a whole-byte boundary and the write-enable latch is set. After such an operation the device stays busy for a programmable number of system clocks, and completion clears the latch. Flash semantics apply: program can only clear bits, and erase sets bytes to 0xFF.

Top module: `spi_flash_slave`

## Requirements
- R1: Serial clock modes 0 and 3 are both accepted; the idle clock level may be low or high. Input bits are captured on the rising edge, most significant bit first.
- R2: Output bits change after falling edges, most significant bit first. While deselected, `sdo_en` is 0 and `sdo` is 0.
- R3: Opcode 0x9F returns 0x20 and then 0x15 in the two bytes that follow; later bytes read 0x00.
- R4: Opcode 0xAB returns 0x14 on every byte after three dummy bytes, and receiving this opcode leaves deep power-down.
- R5: Opcode 0x05 returns the status byte on every following byte. Bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protection level, and the other bits are 0.
- R6: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R7: Opcodes 0x02, 0xD8, 0xC7 and 0x01 take effect only with the latch set and chip select rising after a whole number of bytes. Otherwise nothing changes. A completed operation clears the latch.
- R8: Opcode 0x03 with a 3-byte address returns sequential bytes, wrapping at the array end. Opcode 0x02 ANDs its data bytes into the array, and bytes past the end of the page wrap to the start of that page.
- R9: Opcode 0xD8 sets every byte of the addressed sector to 0xFF. Opcode 0xC7 sets the whole array to 0xFF, but only when the protection level is 0.
- R10: For a protection level n > 0, the top min(array size, sector size × 2^(n-1)) bytes are protected. A program or sector erase that targets a protected page or sector is ignored. Opcode 0x01 loads the level from bits 4:2 of its data byte.
- R11: An accepted program, erase or status write holds busy at 1 for exactly BUSY_CYCLES clocks. During that time only status reads act; other commands are ignored and return 0x00.
- R12: Opcode 0xB9 enters deep power-down. There, every opcode except 0xAB is ignored and returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the bus master |
| sdi | input | 1 | Serial data into the device |
| sdo | output | 1 | Serial data out of the device |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
The checker watches several properties on every cycle. The output enable must be released once chip select has been high for three clocks. Busy must last exactly the programmed count, and its end must leave the write latch clear. The protection level may change only as a status write starts. Neither the latch nor power-down may be entered while busy. Array contents, identification bytes, page wrap, byte-boundary gating and the protection map across all eight levels can only be shown by the bench. It compares read-back data in both clock modes against an arithmetic model of the array.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'hD8;
    localparam logic [7:0] OP_BE   = 8'hC7;
    localparam logic [7:0] OP_RDID = 8'h9F;
    localparam logic [7:0] OP_DPD  = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;

    localparam logic [7:0] ID_MFR  = 8'h20;
    localparam logic [7:0] ID_DEV  = 8'h15;
    localparam logic [7:0] ID_OLD  = 8'h14;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic sel,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    typedef struct packed {
        logic [2:0] cs;
        logic [2:0] ck;
        logic [1:0] di;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.cs = {s_q.cs[1:0], cs_n};
        s_d.ck = {s_q.ck[1:0], sck};
        s_d.di = {s_q.di[0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cs: 3'b111, ck: 3'b000, di: 2'b00};
        else        s_q <= s_d;
    end

    assign sel      = ~s_q.cs[1];
    assign cs_rise  = s_q.cs[1] & ~s_q.cs[2];
    assign sck_rise = s_q.ck[1] & ~s_q.ck[2];
    assign sck_fall = ~s_q.ck[1] & s_q.ck[2];
    assign sdi_s    = s_q.di[1];
endmodule

// File: rtl/spi_prot_decode.sv
module spi_prot_decode #(
    parameter int MEM_BYTES    = 64,
    parameter int SECTOR_BYTES = 16,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic [2:0]    level,
    input  logic [AW-1:0] addr,
    output logic          prot
);
    logic [31:0] span;

    always_comb begin
        span = 32'(SECTOR_BYTES) << (level - 3'd1);
        if (level == 3'd0)                prot = 1'b0;
        else if (span >= 32'(MEM_BYTES))  prot = 1'b1;
        else                              prot = 32'(addr) >= (32'(MEM_BYTES) - span);
    end
endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave
    import spi_flash_pkg::*;
#(
    parameter int MEM_BYTES    = 64,
    parameter int PAGE_BYTES   = 8,
    parameter int SECTOR_BYTES = 16,
    parameter int BUSY_CYCLES  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int SW = $clog2(SECTOR_BYTES);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [2:0]                       bitcnt;
        logic [2:0]                       bytecnt;
        logic [7:0]                       shin;
        logic [7:0]                       op;
        logic [23:0]                      addr;
        logic [2:0]                       sbuf;
        logic [7:0]                       tx;
        logic                             wel;
        logic [2:0]                       bp;
        logic                             busy;
        logic [CW-1:0]                    bcnt;
        logic                             dpd;
        logic [PAGE_BYTES-1:0]            pmask;
        logic [PAGE_BYTES-1:0][7:0]       pbuf;
        logic [MEM_BYTES-1:0][7:0]        mem;
    } st_t;

    st_t st_d, st_q;

    logic sel, cs_rise, sck_rise, sck_fall, sdi_s, prot;
    logic [7:0] sh, txb, status;
    logic blk_out, blk_exec;
    logic [AW-1:0] a_lo;
    logic unused_addr_hi;

    spi_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sel(sel), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .sdi_s(sdi_s)
    );

    assign a_lo = st_q.addr[AW-1:0];
    assign unused_addr_hi = ^st_q.addr[23:AW];

    spi_prot_decode #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_prot (
        .level(st_q.bp), .addr(a_lo), .prot(prot)
    );

    assign status   = {3'b000, st_q.bp, st_q.wel, st_q.busy};
    assign blk_out  = (st_q.busy && st_q.op != OP_RDSR) || (st_q.dpd && st_q.op != OP_RES);
    assign blk_exec = st_q.busy || st_q.dpd;
    assign sh       = {st_q.shin[6:0], sdi_s};

    always_comb begin
        txb = 8'h00;
        unique case (st_q.op)
            OP_RDSR: txb = status;
            OP_RDID: txb = (st_q.bytecnt == 3'd1) ? ID_MFR :
                           (st_q.bytecnt == 3'd2) ? ID_DEV : 8'h00;
            OP_RES:  txb = (st_q.bytecnt >= 3'd4) ? ID_OLD : 8'h00;
            OP_READ: txb = (st_q.bytecnt >= 3'd4) ? st_q.mem[a_lo] : 8'h00;
            default: txb = 8'h00;
        endcase
        if (blk_out || st_q.bytecnt == 3'd0) txb = 8'h00;
    end

    always_comb begin
        st_d = st_q;

        if (st_q.busy) begin
            if (st_q.bcnt <= CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                st_d.bcnt = '0;
            end else begin
                st_d.bcnt = st_q.bcnt - CW'(1);
            end
        end

        if (sel && sck_rise) begin
            st_d.shin   = sh;
            st_d.bitcnt = st_q.bitcnt + 3'd1;
            if (st_q.bitcnt == 3'd7) begin
                if (st_q.bytecnt != 3'd7) st_d.bytecnt = st_q.bytecnt + 3'd1;
                if (st_q.bytecnt == 3'd0) begin
                    st_d.op = sh;
                    if (st_q.dpd && sh == OP_RES) st_d.dpd = 1'b0;
                end else if (st_q.bytecnt <= 3'd3) begin
                    st_d.addr = {st_q.addr[15:0], sh};
                    if (st_q.bytecnt == 3'd1) st_d.sbuf = sh[4:2];
                end else if (st_q.op == OP_PP) begin
                    st_d.pbuf[st_q.addr[PW-1:0]]  = sh;
                    st_d.pmask[st_q.addr[PW-1:0]] = 1'b1;
                    st_d.addr[PW-1:0]             = st_q.addr[PW-1:0] + PW'(1);
                end
            end
        end

        if (sel && sck_fall) begin
            if (st_q.bitcnt == 3'd0) begin
                st_d.tx = txb;
                if (st_q.op == OP_READ && st_q.bytecnt >= 3'd4 && !blk_out)
                    st_d.addr[AW-1:0] = a_lo + AW'(1);
            end else begin
                st_d.tx = {st_q.tx[6:0], 1'b0};
            end
        end

        if (cs_rise && st_q.bitcnt == 3'd0 && st_q.bytecnt != 3'd0 && !blk_exec) begin
            unique case (st_q.op)
                OP_WREN: st_d.wel = 1'b1;
                OP_WRDI: st_d.wel = 1'b0;
                OP_DPD:  st_d.dpd = 1'b1;
                OP_WRSR: if (st_q.wel && st_q.bytecnt >= 3'd2) begin
                    st_d.bp   = st_q.sbuf;
                    st_d.busy = 1'b1;
                    st_d.bcnt = CW'(BUSY_CYCLES);
                end
                OP_PP: if (st_q.wel && st_q.bytecnt >= 3'd5 && !prot) begin
                    for (int i = 0; i < PAGE_BYTES; i++)
                        if (st_q.pmask[i])
                            st_d.mem[{a_lo[AW-1:PW], PW'(i)}] =
                                st_q.mem[{a_lo[AW-1:PW], PW'(i)}] & st_q.pbuf[i];
                    st_d.busy = 1'b1;
                    st_d.bcnt = CW'(BUSY_CYCLES);
                end
                OP_SE: if (st_q.wel && st_q.bytecnt >= 3'd4 && !prot) begin
                    for (int j = 0; j < SECTOR_BYTES; j++)
                        st_d.mem[{a_lo[AW-1:SW], SW'(j)}] = 8'hFF;
                    st_d.busy = 1'b1;
                    st_d.bcnt = CW'(BUSY_CYCLES);
                end
                OP_BE: if (st_q.wel && st_q.bp == 3'd0) begin
                    st_d.mem  = '1;
                    st_d.busy = 1'b1;
                    st_d.bcnt = CW'(BUSY_CYCLES);
                end
                default: ;
            endcase
        end

        if (!sel) begin
            st_d.bitcnt  = '0;
            st_d.bytecnt = '0;
            st_d.pmask   = '0;
            st_d.tx      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.mem <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_en = sel;
    assign sdo    = sel & st_q.tx[7];

    logic stat_busy, stat_wel, stat_dpd;
    logic [2:0] stat_bp;
    assign stat_busy = st_q.busy;
    assign stat_wel  = st_q.wel;
    assign stat_dpd  = st_q.dpd;
    assign stat_bp   = st_q.bp;
endmodule

// File: rtl/spi_flash_slave_chk.sv
module spi_flash_slave_chk #(
    parameter int BUSY_CYCLES = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo_en,
    input logic       busy,
    input logic       wel,
    input logic       dpd,
    input logic [2:0] bp
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 32'd1;
        else           run_q <= '0;
    end

    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_en);

    // R11
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == 32'(BUSY_CYCLES));

    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R10
    bp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $rose(busy));

    // R11
    wel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy));

    // R12
    dpd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpd) |-> !$past(busy));
endmodule

bind spi_flash_slave spi_flash_slave_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_en(sdo_en),
    .busy(stat_busy), .wel(stat_wel), .dpd(stat_dpd), .bp(stat_bp)
);

// File: tb/spi_flash_slave_tb.sv
module spi_flash_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM = 64;
    localparam int PAGE = 8;
    localparam int SECT = 16;
    localparam int BUSY = 600;
    localparam int H = 5;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo, sdo_en;
    int nchk = 0, nfail = 0;
    bit m3 = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_mem [MEM];
    bit m_wel = 1'b0;
    logic [2:0] m_bp = 3'd0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_flash_slave #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .SECTOR_BYTES(SECT),
                      .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_prot(input logic [2:0] lv, input int a);
        int span;
        if (lv == 0) return 1'b0;
        span = SECT << (lv - 1);
        if (span >= MEM) return 1'b1;
        return a >= MEM - span;
    endfunction

    task automatic begin_t();
        @(negedge clk) sck = m3;
        repeat (H) @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic end_t();
        if (!m3) begin
            sck = 1'b0;
            repeat (H) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b > 7 - n; b--) begin
            sck = 1'b0;
            sdi = tx[b];
            repeat (H) @(negedge clk);
            rx[b] = sdo;
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        begin_t();
        xbyte(op, r);
        end_t();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        begin_t();
        xbyte(8'h05, r);
        xbyte(8'h00, s);
        end_t();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
        m_wel = 1'b0;
    endtask

    task automatic stat_chk(input string req);
        logic [7:0] s;
        rdsr(s);
        chk(req, s, {3'b000, m_bp, m_wel, 1'b0});
    endtask

    task automatic send_addr(input logic [7:0] op, input int a);
        logic [7:0] r;
        xbyte(op, r);
        xbyte(8'h00, r);
        xbyte(8'h00, r);
        xbyte(8'(a), r);
    endtask

    task automatic wren();
        cmd1(8'h06);
        m_wel = 1'b1;
    endtask

    task automatic pp(input int a, input int n, input logic [7:0] seed);
        logic [7:0] r;
        bit ok;
        ok = m_wel && !is_prot(m_bp, a);
        begin_t();
        send_addr(8'h02, a);
        for (int k = 0; k < n; k++) begin
            xbyte(8'(seed + k), r);
            if (ok) exp_mem[(a & ~(PAGE - 1)) | ((a + k) % PAGE)] &= 8'(seed + k);
        end
        end_t();
        if (!ok) m_wel = m_wel;
    endtask

    task automatic read_chk(input int a, input int n, input string req);
        logic [7:0] r;
        begin_t();
        send_addr(8'h03, a);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, r);
            chk(req, r, exp_mem[(a + k) % MEM]);
        end
        end_t();
    endtask

    task automatic wrsr(input logic [2:0] lv);
        logic [7:0] r;
        wren();
        begin_t();
        xbyte(8'h01, r);
        xbyte({3'b000, lv, 2'b00}, r);
        end_t();
        m_bp = lv;
        wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, s;
        bit ok;
        for (int i = 0; i < MEM; i++) exp_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: deselected output released
        chk("R2 oe idle", sdo_en, 1'b0);
        chk("R2 sdo idle", sdo, 1'b0);
        // R5: reset status
        stat_chk("R5 reset status");
        // R8: erased array after reset, read wraps at array end
        read_chk(60, 8, "R8 reset read wrap");

        // R1 R3: identification in both modes
        for (int md = 0; md < 2; md++) begin
            m3 = md[0];
            begin_t();
            chk("R2 oe selected", sdo_en, 1'b1);
            xbyte(8'h9F, r);
            xbyte(8'h00, r); chk("R3 R1 id byte0", r, 8'h20);
            xbyte(8'h00, r); chk("R3 R1 id byte1", r, 8'h15);
            xbyte(8'h00, r); chk("R3 id tail", r, 8'h00);
            end_t();
        end
        m3 = 1'b0;

        // R4: legacy signature after three dummies
        begin_t();
        send_addr(8'hAB, 0);
        xbyte(8'h00, r); chk("R4 sig", r, 8'h14);
        xbyte(8'h00, r); chk("R4 sig repeat", r, 8'h14);
        end_t();

        // R6: latch set and clear
        wren(); stat_chk("R6 wren");
        cmd1(8'h04); m_wel = 1'b0; stat_chk("R6 wrdi");

        // R7: program without latch ignored
        pp(3, 2, 8'h11);
        read_chk(3, 2, "R7 no latch");

        // R8 R11: program wraps within page, busy visible with latch
        wren();
        pp(13, 6, 8'hA0);
        rdsr(s); chk("R11 busy during program", s, 8'h03);
        wait_idle();
        stat_chk("R7 latch cleared on completion");
        read_chk(8, 8, "R8 page wrap");
        wren(); pp(9, 2, 8'h0F); wait_idle();
        read_chk(8, 4, "R8 and program");

        // R7: chip select rising mid-byte ignored
        wren();
        begin_t();
        send_addr(8'h02, 20);
        xbyte(8'h00, r);
        xbits(8'h00, 3, r);
        end_t();
        stat_chk("R7 mid-byte latch kept");
        read_chk(20, 1, "R7 mid-byte no write");
        cmd1(8'h04); m_wel = 1'b0;

        // R9 R11: sector erase, commands ignored while busy
        wren(); pp(17, 1, 8'h00); wait_idle();
        wren(); pp(33, 1, 8'h00); wait_idle();
        wren();
        begin_t(); send_addr(8'hD8, 18); end_t();
        for (int j = 16; j < 32; j++) exp_mem[j] = 8'hFF;
        begin_t();
        xbyte(8'h9F, r);
        xbyte(8'h00, r); chk("R11 id ignored when busy", r, 8'h00);
        end_t();
        cmd1(8'h06);
        rdsr(s); chk("R11 status while busy", s, 8'h03);
        wait_idle();
        stat_chk("R11 wren ignored when busy");
        read_chk(16, 2, "R9 sector erased");
        read_chk(32, 2, "R9 other sector kept");

        // R12 R4: deep power-down
        wren();
        cmd1(8'hB9);
        rdsr(s); chk("R12 status ignored", s, 8'h00);
        cmd1(8'h04);
        begin_t();
        xbyte(8'h9F, r);
        xbyte(8'h00, r); chk("R12 id ignored", r, 8'h00);
        end_t();
        begin_t();
        send_addr(8'hAB, 0);
        xbyte(8'h00, r); chk("R4 wake sig", r, 8'h14);
        end_t();
        stat_chk("R12 wrdi ignored, R4 awake");
        cmd1(8'h04); m_wel = 1'b0;

        // R10 R9: protection sweep over every level and sector
        for (int lv = 0; lv < 8; lv++) begin
            m3 = lv[0];
            wrsr(3'(lv));
            stat_chk("R10 level written");
            for (int sc = 0; sc < MEM / SECT; sc++) begin
                wren();
                pp(sc * SECT + 2 + lv, 1, 8'(8'h5A ^ lv));
                wait_idle();
                if (is_prot(3'(lv), sc * SECT)) m_wel = 1'b1;
                stat_chk("R10 R7 latch after program");
                if (m_wel) begin cmd1(8'h04); m_wel = 1'b0; end
            end
            for (int sc = 0; sc < MEM / SECT; sc++)
                read_chk(sc * SECT + 2 + lv, 1, "R10 protected map");
            wren();
            begin_t(); xbyte(8'hC7, r); end_t();
            ok = (lv == 0);
            if (ok) for (int i = 0; i < MEM; i++) exp_mem[i] = 8'hFF;
            wait_idle();
            if (!ok) begin cmd1(8'h04); end
            read_chk(2 + lv, 1, "R9 bulk erase gated");
        end

        // R9: final bulk erase restores the array
        m3 = 1'b0;
        wrsr(3'd0);
        wren();
        begin_t(); xbyte(8'hC7, r); end_t();
        for (int i = 0; i < MEM; i++) exp_mem[i] = 8'hFF;
        wait_idle();
        read_chk(0, MEM, "R9 bulk erase");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule